// File: doc/BRIEF.md
# Color-Bar Background Overlay Compositor

This block generates a progressive video raster and composites a streamed foreground picture onto a generated background. The background consists of eight vertical color bars of equal width spanning the visible line. The foreground arrives as a valid/ready pixel stream carrying frame-start and line-end markers. It passes through an on-chip pixel FIFO and is drawn from the top-left corner of the raster. Wherever the raster lies outside the foreground window, or the FIFO has no pixel ready, the bar color is shown instead.

The default geometry is a 1920x1200 active area. Each line has 1920 visible pixels, then 48 pixels of front porch, a 32-pixel sync pulse and 80 pixels of back porch, for 2080 clocks per line. Each frame has 1200 visible lines, then 3 lines of front porch, 6 sync lines and 26 lines of back porch, for 1235 lines per frame. At 60 Hz this needs a pixel clock of about 154 MHz. Horizontal sync is active high and vertical sync is active low. The default foreground is 1920x1080, so lines 1080 and beyond show only bars. The raster does not start after reset until the FIFO has been primed to a set fill level. From then on it runs freely, one 24-bit pixel per clock.

All geometry, the FIFO depth and the start level are parameters. A wrong marker position in the stream, and a starved foreground pixel, each raise a sticky flag.

Top module: `cbar_compositor`

## Requirements
- R1: While reset is held, out_de and out_hsync are 0, out_vsync_n is 1, out_pixel is 0, both flags are 0, and in_ready is 1.
- R2: No raster is produced (out_de 0, out_hsync 0, out_vsync_n 1) until the FIFO holds at least START_LEVEL pixels. The first output cycle after that is the first active pixel of line 0.
- R3: Each line lasts H_ACT+H_FP+H_SYNC+H_BP clocks. out_hsync is 1 for exactly H_SYNC clocks, beginning H_FP clocks after the last active pixel.
- R4: Each frame lasts V_ACT+V_FP+V_SYNC+V_BP lines. out_vsync_n is 0 for exactly V_SYNC whole lines, beginning V_FP lines after the last active line.
- R5: out_de is 1 exactly for pixels x < H_ACT on lines y < V_ACT.
- R6: Active positions with x < FG_W and y < FG_H output the accepted stream pixels in order, one per position, in row-major order.
- R7: Other active positions show bar index floor(x*8/H_ACT). The bus is R in bits 23:16, G in bits 15:8 and B in bits 7:0. Index 0..7 maps to FFFFFF, FFFF00, 00FFFF, 00FF00, FF00FF, FF0000, 0000FF, 000000.
- R8: out_pixel is 0 whenever out_de is 0.
- R9: A foreground position met with an empty FIFO shows its bar color, and underflow goes to 1 in that same output cycle. underflow stays 1 until reset.
- R10: align_err goes to 1 and stays 1 until reset when a popped pixel's frame-start marker disagrees with its position being (0,0), or its line-end marker disagrees with x being FG_W-1.
- R11: in_ready equals "FIFO not full". A pixel is accepted on a clock edge where in_valid and in_ready are both 1, and no accepted pixel is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Foreground pixel offered |
| in_ready | output | 1 | FIFO can accept a pixel |
| in_data | input | 24 | Foreground pixel, R/G/B 8 bits each |
| in_sof | input | 1 | Marks the first pixel of a foreground frame |
| in_eol | input | 1 | Marks the last pixel of a foreground line |
| out_pixel | output | 24 | Composited pixel |
| out_de | output | 1 | Active-area data enable |
| out_hsync | output | 1 | Horizontal sync, active high |
| out_vsync_n | output | 1 | Vertical sync, active low |
| underflow | output | 1 | Sticky: foreground pixel was missing |
| align_err | output | 1 | Sticky: stream marker out of place |

## Verification
Two events can fall in the same clock: a stream push and a foreground pop. The raster starts with the FIFO one short of full while the producer keeps pushing every cycle. As a result, the FIFO fills during blanking, and pushes and pops coincide on every foreground pixel. The bench judges this by requiring every foreground position to carry exactly the next accepted pixel, with in_ready seen low at least once and no underflow. A second run starves the FIFO part-way through a foreground line. It requires the bar color and the underflow flag to appear in the same output cycle.

// File: rtl/cbar_pkg.sv
// Shared definitions for the color-bar compositor.
// Assumes 8 bits per color plane, three planes, R in the top byte.
package cbar_pkg;

    localparam int PIX_W = 24;

    typedef logic [PIX_W-1:0] pix_t;

    // Map a bar index (0 = leftmost) to its RGB value.
    function automatic pix_t bar_rgb(input logic [2:0] idx);
        pix_t c;
        unique case (idx)
            3'd0:    c = 24'hFF_FF_FF;
            3'd1:    c = 24'hFF_FF_00;
            3'd2:    c = 24'h00_FF_FF;
            3'd3:    c = 24'h00_FF_00;
            3'd4:    c = 24'hFF_00_FF;
            3'd5:    c = 24'hFF_00_00;
            3'd6:    c = 24'h00_00_FF;
            default: c = 24'h00_00_00;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cbar_fifo.sv
// Synchronous pixel FIFO with show-ahead read data and a fill-level output.
// Assumes the caller never pushes when full nor pops when empty.
// DEPTH need not be a power of two.
module cbar_fifo #(
    parameter int DEPTH = 1920,
    parameter int W     = 26,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_MAX  = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    assign full  = (level == LVL_MAX);
    assign empty = (level == '0);
    assign rdata = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
            end
            if (push && !pop) begin
                level <= level + LW'(1);
            end else if (pop && !push) begin
                level <= level - LW'(1);
            end
        end
    end

    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    p_push_room_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_level_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);

    p_level_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (level == $past(level) + LW'(1)));

endmodule

// File: rtl/cbar_timing.sv
// Raster position counters and sync decode.
// Counting order within a line: active, front porch, sync, back porch.
// The frame uses the same order, line by line. Counters hold at the
// origin while run is low. All porches are assumed non-zero.
module cbar_timing #(
    parameter int H_ACT  = 1920,
    parameter int H_FP   = 48,
    parameter int H_SYNC = 32,
    parameter int H_BP   = 80,
    parameter int V_ACT  = 1200,
    parameter int V_FP   = 3,
    parameter int V_SYNC = 6,
    parameter int V_BP   = 26,
    parameter int HW     = $clog2(H_ACT + H_FP + H_SYNC + H_BP),
    parameter int VW     = $clog2(V_ACT + V_FP + V_SYNC + V_BP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          act,
    output logic          hs,
    output logic          vs_n
);

    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;

    localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACT);
    localparam logic [HW-1:0] HS_BEG   = HW'(H_ACT + H_FP);
    localparam logic [HW-1:0] HS_END   = HW'(H_ACT + H_FP + H_SYNC);
    localparam logic [HW-1:0] H_LAST   = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACT);
    localparam logic [VW-1:0] VS_BEG   = VW'(V_ACT + V_FP);
    localparam logic [VW-1:0] VS_END   = VW'(V_ACT + V_FP + V_SYNC);
    localparam logic [VW-1:0] V_LAST   = VW'(V_TOT - 1);

    // Advance the pixel and line counters while the raster runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (run) begin
            if (h_pos == H_LAST) begin
                h_pos <= '0;
                v_pos <= (v_pos == V_LAST) ? '0 : v_pos + VW'(1);
            end else begin
                h_pos <= h_pos + HW'(1);
            end
        end
    end

    // Decode the active window and the two sync pulses from position.
    always_comb begin
        act  = (h_pos < H_ACT_C) && (v_pos < V_ACT_C);
        hs   = (h_pos >= HS_BEG) && (h_pos < HS_END);
        vs_n = !((v_pos >= VS_BEG) && (v_pos < VS_END));
    end

    p_hpos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h_pos <= H_LAST);

    p_hwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_pos == H_LAST) |=> (h_pos == '0));

    p_vpos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v_pos <= V_LAST);

    p_vstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_pos != H_LAST) |=> $stable(v_pos));

endmodule

// File: rtl/cbar_bars.sv
// Background generator: eight equal vertical bars across the active width.
// The bar index is floor(x*8/H_ACT), built from seven edge comparators
// so that no divider is needed.
module cbar_bars
    import cbar_pkg::*;
#(
    parameter int H_ACT = 1920,
    parameter int XW    = 12
) (
    input  logic [XW-1:0] x,
    output pix_t          rgb
);

    logic [6:0] past_edge;
    logic [2:0] idx;

    // One comparator per bar boundary: x*8 >= g*H_ACT means x >= ceil(g*H_ACT/8).
    for (genvar g = 1; g < 8; g++) begin : g_edge
        localparam int EDGE = (g * H_ACT + 7) / 8;
        assign past_edge[g-1] = (x >= XW'(EDGE));
    end

    // Count the boundaries passed and look up the bar color.
    always_comb begin
        idx = '0;
        for (int i = 0; i < 7; i++) begin
            idx = idx + 3'(past_edge[i]);
        end
        rgb = bar_rgb(idx);
    end

endmodule

// File: rtl/cbar_compositor.sv
// Top level: primes the pixel FIFO, starts the raster once START_LEVEL
// pixels are held, and composites the foreground over the color bars.
// Outputs are registered one clock after the position counters.
// Assumes FG_W <= H_ACT, FG_H <= V_ACT and START_LEVEL <= FIFO_DEPTH.
module cbar_compositor
    import cbar_pkg::*;
#(
    parameter int H_ACT       = 1920,
    parameter int H_FP        = 48,
    parameter int H_SYNC      = 32,
    parameter int H_BP        = 80,
    parameter int V_ACT       = 1200,
    parameter int V_FP        = 3,
    parameter int V_SYNC      = 6,
    parameter int V_BP        = 26,
    parameter int FG_W        = 1920,
    parameter int FG_H        = 1080,
    parameter int FIFO_DEPTH  = 1920,
    parameter int START_LEVEL = 1919
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [23:0] in_data,
    input  logic        in_sof,
    input  logic        in_eol,
    output logic [23:0] out_pixel,
    output logic        out_de,
    output logic        out_hsync,
    output logic        out_vsync_n,
    output logic        underflow,
    output logic        align_err
);

    localparam int HW = $clog2(H_ACT + H_FP + H_SYNC + H_BP);
    localparam int VW = $clog2(V_ACT + V_FP + V_SYNC + V_BP);
    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam int FW = PIX_W + 2;

    localparam logic [HW-1:0] FG_W_C   = HW'(FG_W);
    localparam logic [HW-1:0] FG_XLAST = HW'(FG_W - 1);
    localparam logic [VW-1:0] FG_H_C   = VW'(FG_H);
    localparam logic [LW-1:0] START_C  = LW'(START_LEVEL);

    logic          running;
    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic          t_act, t_hs, t_vs_n;
    logic          push, pop, fifo_full, fifo_empty;
    logic [LW-1:0] fifo_lvl;
    logic [FW-1:0] fifo_q;
    pix_t          fg_pix, bg_pix;
    logic          fg_sof, fg_eol;
    logic          fg_zone, starve, mark_bad;

    assign in_ready = !fifo_full;
    assign push     = in_valid && in_ready;

    cbar_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (FW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({in_sof, in_eol, in_data}),
        .pop   (pop),
        .rdata (fifo_q),
        .full  (fifo_full),
        .empty (fifo_empty),
        .level (fifo_lvl)
    );

    cbar_timing #(
        .H_ACT  (H_ACT),
        .H_FP   (H_FP),
        .H_SYNC (H_SYNC),
        .H_BP   (H_BP),
        .V_ACT  (V_ACT),
        .V_FP   (V_FP),
        .V_SYNC (V_SYNC),
        .V_BP   (V_BP)
    ) u_timing (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .h_pos (h_pos),
        .v_pos (v_pos),
        .act   (t_act),
        .hs    (t_hs),
        .vs_n  (t_vs_n)
    );

    cbar_bars #(
        .H_ACT (H_ACT),
        .XW    (HW)
    ) u_bars (
        .x   (h_pos),
        .rgb (bg_pix)
    );

    // Latch the start of the raster once the FIFO is primed; never stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else if (fifo_lvl >= START_C) begin
            running <= 1'b1;
        end
    end

    // Decide whether this position takes a foreground pixel, and check its markers.
    always_comb begin
        {fg_sof, fg_eol, fg_pix} = fifo_q;
        fg_zone  = running && (h_pos < FG_W_C) && (v_pos < FG_H_C);
        pop      = fg_zone && !fifo_empty;
        starve   = fg_zone && fifo_empty;
        mark_bad = (fg_sof != ((h_pos == '0) && (v_pos == '0)))
                || (fg_eol != (h_pos == FG_XLAST));
    end

    // Register the composited pixel, syncs and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pixel   <= '0;
            out_de      <= 1'b0;
            out_hsync   <= 1'b0;
            out_vsync_n <= 1'b1;
            underflow   <= 1'b0;
            align_err   <= 1'b0;
        end else begin
            out_de      <= running && t_act;
            out_hsync   <= running && t_hs;
            out_vsync_n <= !running || t_vs_n;
            if (!(running && t_act)) begin
                out_pixel <= '0;
            end else if (pop) begin
                out_pixel <= fg_pix;
            end else begin
                out_pixel <= bg_pix;
            end
            underflow <= underflow || starve;
            align_err <= align_err || (pop && mark_bad);
        end
    end

    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> ($past(fifo_lvl) >= START_C));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!out_de && !out_hsync && out_vsync_n));

    p_sync_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hsync || !out_vsync_n) |-> !out_de);

    p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_pixel == '0));

    p_uf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    p_ae_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> align_err);

endmodule

// File: tb/cbar_compositor_tb.sv
// Directed bench with a small raster: 16x6 active, 25 clocks by 11 lines,
// a 12x4 foreground and a 16-entry FIFO that starts the raster at 15.
module cbar_compositor_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H_ACT = 16, H_FP = 2, H_SYNC = 3, H_BP = 4;
    localparam int V_ACT = 6,  V_FP = 1, V_SYNC = 2, V_BP = 2;
    localparam int FG_W = 12, FG_H = 4, DEPTH = 16, START = 15;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int F_TOT = H_TOT * V_TOT;
    localparam int FG_N  = FG_W * FG_H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid, in_ready, in_sof, in_eol;
    logic [23:0] in_data;
    logic [23:0] out_pixel;
    logic        out_de, out_hsync, out_vsync_n, underflow, align_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] exp_q[$];
    bit prod_en = 1'b0;
    int prod_limit = 0;
    int prod_sent = 0;
    int k_pix = 0;
    int frame_no = 0;
    int bad_sof_at = 0;
    bit saw_full = 1'b0;

    always #2.5 clk = ~clk;

    cbar_compositor #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .FG_W(FG_W), .FG_H(FG_H), .FIFO_DEPTH(DEPTH), .START_LEVEL(START)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eol(in_eol),
        .out_pixel(out_pixel), .out_de(out_de), .out_hsync(out_hsync),
        .out_vsync_n(out_vsync_n), .underflow(underflow), .align_err(align_err)
    );

    function automatic logic [23:0] bar_exp(input int x);
        int idx = (x * 8) / H_ACT;
        case (idx)
            0: return 24'hFFFFFF;
            1: return 24'hFFFF00;
            2: return 24'h00FFFF;
            3: return 24'h00FF00;
            4: return 24'hFF00FF;
            5: return 24'hFF0000;
            6: return 24'h0000FF;
            default: return 24'h000000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Stream producer: offers pixels at the falling edge; acceptance is known from in_ready.
    initial begin
        in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eol = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prod_en && prod_sent < prod_limit) begin
                in_valid = 1'b1;
                in_data  = {8'(frame_no), 8'(k_pix / FG_W), 8'(k_pix % FG_W)};
                in_sof   = (k_pix == bad_sof_at);
                in_eol   = ((k_pix % FG_W) == FG_W - 1);
                if (in_ready) begin
                    exp_q.push_back(in_data);
                    prod_sent++;
                    if (k_pix == FG_N - 1) begin
                        k_pix = 0;
                        frame_no++;
                    end else begin
                        k_pix++;
                    end
                end else begin
                    saw_full = 1'b1;
                end
            end else begin
                in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
            end
        end
    end

    // R1: apply reset, check the reset state, release.
    task automatic do_reset();
        prod_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        prod_sent = 0; k_pix = 0; frame_no = 0; bad_sof_at = 0; saw_full = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_de === 1'b0,      "R1 de",      32'(out_de), 0);
        chk(out_hsync === 1'b0,   "R1 hsync",   32'(out_hsync), 0);
        chk(out_vsync_n === 1'b1, "R1 vsync_n", 32'(out_vsync_n), 1);
        chk(out_pixel === 24'h0,  "R1 pixel",   32'(out_pixel), 0);
        chk(underflow === 1'b0 && align_err === 1'b0, "R1 flags",
            32'({underflow, align_err}), 0);
        chk(in_ready === 1'b1,    "R1 ready",   32'(in_ready), 1);
        rst_n = 1'b1;
    endtask

    // Follow the raster from its first active pixel and check every output cycle (R2..R9).
    task automatic watch(input int nframes, output int starved);
        int  wait_c = 0;
        bit  uf_exp = 1'b0;
        starved = 0;
        while (out_de !== 1'b1 && wait_c < 3000) begin
            @(negedge clk);
            wait_c++;
        end
        chk(out_de === 1'b1, "R2 raster start", 32'(out_de), 1);
        chk(prod_sent >= START, "R2 start level", 32'(prod_sent), 32'(START));
        for (int c = 0; c < nframes * F_TOT; c++) begin
            int h = c % H_TOT;
            int v = (c / H_TOT) % V_TOT;
            bit de_e = (h < H_ACT) && (v < V_ACT);
            bit hs_e = (h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SYNC);
            bit vs_e = !((v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SYNC));
            logic [23:0] px_e;
            string tag;
            chk(out_de === de_e,      "R5 de",      32'(out_de), 32'(de_e));
            chk(out_hsync === hs_e,   "R3 hsync",   32'(out_hsync), 32'(hs_e));
            chk(out_vsync_n === vs_e, "R4 vsync_n", 32'(out_vsync_n), 32'(vs_e));
            if (!de_e) begin
                px_e = '0; tag = "R8 blank pixel";
            end else if (h < FG_W && v < FG_H) begin
                if (exp_q.size() > 0) begin
                    px_e = exp_q.pop_front(); tag = "R6 foreground";
                end else begin
                    px_e = bar_exp(h); tag = "R9 starved pixel";
                    uf_exp = 1'b1; starved++;
                end
            end else begin
                px_e = bar_exp(h); tag = "R7 bar";
            end
            chk(out_pixel === px_e, tag, 32'(out_pixel), 32'(px_e));
            chk(underflow === uf_exp, "R9 flag", 32'(underflow), 32'(uf_exp));
            @(negedge clk);
        end
    endtask

    // R2/R11: one pixel short of the start level, nothing runs; then stream freely for two frames.
    task automatic t_start_gate();
        int st;
        bit quiet = 1'b1;
        do_reset();
        prod_limit = START - 1;
        prod_en = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (out_de !== 1'b0 || out_hsync !== 1'b0 || out_vsync_n !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R2 held before start level", 32'(quiet), 1);
        chk(in_ready === 1'b1, "R11 ready below full", 32'(in_ready), 1);
        prod_limit = 1000000;
        watch(2, st);
        chk(st == 0, "R9 no starvation", 32'(st), 0);
        chk(saw_full, "R11 backpressure seen", 32'(saw_full), 1);
        chk(align_err === 1'b0, "R10 clean markers", 32'(align_err), 0);
    endtask

    // R9: supply only part of a frame so the FIFO runs dry mid-line.
    task automatic t_underflow();
        int st;
        do_reset();
        prod_limit = FG_W + 5;
        prod_en = 1'b1;
        watch(1, st);
        chk(st == FG_N - (FG_W + 5), "R9 starved count", 32'(st), 32'(FG_N - FG_W - 5));
        chk(underflow === 1'b1, "R9 sticky", 32'(underflow), 1);
        chk(align_err === 1'b0, "R10 partial frame aligned", 32'(align_err), 0);
    endtask

    // R10: frame-start marker placed on the second pixel.
    task automatic t_markers();
        int st;
        do_reset();
        bad_sof_at = 1;
        prod_limit = 1000000;
        prod_en = 1'b1;
        watch(1, st);
        chk(align_err === 1'b1, "R10 misplaced sof", 32'(align_err), 1);
        prod_en = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        t_start_gate();
        t_underflow();
        t_markers();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule